// File: doc/BRIEF.md
# Edge-Triggered Input Capture Unit

This block records the moment an external event happens. It watches one capture input. When that input makes the chosen transition, the block copies the current value of a 16-bit free-running counter into a capture register. The counter is supplied on an input port. Software reads the captured value as two bytes over an 8-bit read bus. A capture flag tells software that a new value is waiting.

Two interlocks keep the two byte reads consistent. First, reading the upper byte blocks any new capture until the lower byte has been read. An edge that arrives during that window is dropped. Second, the flag clears only through a two-step handshake. Software reads the status byte and sees the flag set, then reads the lower capture byte. If a new capture lands between those two steps, the flag stays set, so no event is lost.

Top module: `edge_capture_unit`

## Requirements
- R1: The capture input passes through two synchroniser flops. If the input changes just after a rising clock edge, the capture register holds the value that `cnt_in` had just before the third rising clock edge after the change.
- R2: When `edge_rise` is 1, only a low-to-high transition of the capture input captures. When `edge_rise` is 0, only a high-to-low transition captures. A transition in the other direction changes neither the capture register nor the flag.
- R3: Reads are combinational while `rd_en` is high. Address 0x14 returns capture bits 15:8. Address 0x15 returns capture bits 7:0. Address 0x13 is the status byte, with the capture flag in bit 7 and 0 in all other bits. When `rd_en` is low, `rdata` is 0.
- R4: Every capture that is carried out sets the capture flag on the following clock edge.
- R5: A read of address 0x14 blocks captures, starting with an edge that is detected in the same cycle as that read. The block lasts until a read of address 0x15 completes. A blocked edge is dropped, does not change the capture register and does not set the flag.
- R6: The flag clears on a read of address 0x15 only under two conditions. An earlier status read must have returned the flag as 1. No capture may have happened since that status read, including in the cycle of the 0x15 read itself. A 0x15 read without such a status read leaves the flag unchanged.
- R7: Write cycles (`wr_en`) to any address, including 0x14 and 0x15, change neither the capture register nor the flag.
- R8: Reset clears the flag, the read block and the armed clear state. The capture register keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_in | input | 16 | Free-running counter value |
| cap_pin | input | 1 | Asynchronous capture input |
| edge_rise | input | 1 | Edge select: 1 rising, 0 falling |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (ignored by this block) |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data (ignored by this block) |
| rdata | output | 8 | Read data |
| cap_flag | output | 1 | Capture flag |

## Verification
Two pairs of functions can fall in the same clock cycle:
- A detected edge and a read of the upper capture byte. The bench times the input change so that the synchronised edge lands in the exact cycle of the upper-byte read. It then expects the old register contents on both byte reads and an unchanged flag.
- A capture and an armed lower-byte read. The bench lines up a capture with the lower-byte read that follows a flag-set status read. It expects the old low byte on the bus, the flag still set, and the new counter value on the next byte pair.

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int BUS_W = 8,
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h13,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*BUS_W-1:0]  cnt_in,
  input  logic                cap_pin,
  input  logic                edge_rise,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W-1:0]    wdata,
  output logic [BUS_W-1:0]    rdata,
  output logic                cap_flag
);
  localparam int CNT_W = 2 * BUS_W;

  logic [SYNC_STAGES:0] sync_q;
  logic [CNT_W-1:0]     cap_q;
  logic                 inhibit_q, arm_q, flag_q;
  logic                 pin_now, pin_prev, edge_hit, cap_now;
  logic                 rd_hi, rd_lo, rd_stat;

  assign pin_now  = sync_q[SYNC_STAGES-1];
  assign pin_prev = sync_q[SYNC_STAGES];
  assign edge_hit = edge_rise ? (pin_now & ~pin_prev) : (~pin_now & pin_prev);

  assign rd_hi   = rd_en && (addr == HI_ADDR);
  assign rd_lo   = rd_en && (addr == LO_ADDR);
  assign rd_stat = rd_en && (addr == STAT_ADDR);

  assign cap_now = edge_hit & ~inhibit_q & ~rd_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], cap_pin};
  end

  always_ff @(posedge clk) begin
    if (cap_now) cap_q <= cnt_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inhibit_q <= 1'b0;
      arm_q     <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (rd_hi)      inhibit_q <= 1'b1;
      else if (rd_lo) inhibit_q <= 1'b0;

      if (cap_now)                arm_q <= 1'b0;
      else if (rd_stat && flag_q) arm_q <= 1'b1;
      else if (rd_lo)             arm_q <= 1'b0;

      if (cap_now)             flag_q <= 1'b1;
      else if (rd_lo && arm_q) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_hi)        rdata = cap_q[CNT_W-1:BUS_W];
    else if (rd_lo)   rdata = cap_q[BUS_W-1:0];
    else if (rd_stat) rdata = {flag_q, {(BUS_W-1){1'b0}}};
  end

  assign cap_flag = flag_q;

  logic unused_ok;
  assign unused_ok = ^{wr_en, wdata};

  AST_CAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_now |=> cap_flag); // R4
  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_q || rd_hi) |=> $stable(cap_q)); // R5
  AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> flag_q); // R6
  AST_CLEAR_ON_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(rd_lo)); // R6
  AST_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !edge_hit) |=> ($stable(cap_q) && $stable(flag_q))); // R7
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0)); // R3
endmodule

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;
  logic clk = 0, rst_n = 0, cap_pin = 0, edge_rise = 1;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [15:0] cnt = 16'h1234;
  logic cap_flag;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  logic [15:0] last_cap;

  always #2 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 16'd1;

  edge_capture_unit uut (.clk(clk), .rst_n(rst_n), .cnt_in(cnt), .cap_pin(cap_pin),
    .edge_rise(edge_rise), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_flag(cap_flag));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); wr_en = 1; addr = a; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic drive_pin(input logic v, input bit expect_cap);
    @(negedge clk); cap_pin = v;
    @(negedge clk);
    @(negedge clk);
    #1 if (expect_cap) exp_q.push_back(cnt);
    @(negedge clk);
  endtask

  task automatic pop_check(input string req);
    logic [7:0] h, l;
    logic [15:0] e;
    bus_read(8'h14, h);
    bus_read(8'h15, l);
    if (exp_q.size() > 0) e = exp_q.pop_front(); else e = last_cap;
    chk(req, {h, l}, e);
    last_cap = e;
  endtask

  task automatic clear_flag();
    logic [7:0] d;
    bus_read(8'h13, d);
    bus_read(8'h15, d);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] snap;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1 chk("R8 flag after reset", {15'd0, cap_flag}, 16'd0);
    chk("R3 idle bus", {8'd0, rdata}, 16'd0);
    bus_read(8'h13, d);
    chk("R8 status after reset", {8'd0, d}, 16'd0);

    drive_pin(1, 1);
    #1 chk("R4 flag on capture", {15'd0, cap_flag}, 16'd1);
    pop_check("R1 captured counter");
    chk("R6 lo read without status keeps flag", {15'd0, cap_flag}, 16'd1);

    drive_pin(0, 0);
    pop_check("R2 falling ignored in rising mode");

    bus_read(8'h13, d);
    chk("R3 status bit7", {8'd0, d}, 16'h0080);
    bus_read(8'h15, d);
    chk("R6 handshake clears flag", {15'd0, cap_flag}, 16'd0);

    edge_rise = 0;
    drive_pin(1, 0);
    chk("R2 rising ignored in falling mode", {15'd0, cap_flag}, 16'd0);
    drive_pin(0, 1);
    chk("R2 falling captures", {15'd0, cap_flag}, 16'd1);
    pop_check("R2 falling value");

    edge_rise = 1;
    clear_flag();
    bus_read(8'h14, d);
    chk("R3 hi byte", {8'd0, d}, {8'd0, last_cap[15:8]});
    drive_pin(1, 0);
    chk("R5 blocked edge no flag", {15'd0, cap_flag}, 16'd0);
    bus_read(8'h15, d);
    chk("R5 lo byte coherent", {8'd0, d}, {8'd0, last_cap[7:0]});
    drive_pin(0, 0);
    drive_pin(1, 1);
    pop_check("R5 capture after release");

    drive_pin(0, 0);
    clear_flag();
    @(negedge clk); cap_pin = 1;
    @(negedge clk);
    bus_read(8'h14, d);
    chk("R5 same-cycle hi read old byte", {8'd0, d}, {8'd0, last_cap[15:8]});
    repeat (2) @(negedge clk);
    chk("R5 same-cycle edge no flag", {15'd0, cap_flag}, 16'd0);
    bus_read(8'h15, d);
    chk("R5 same-cycle edge dropped", {8'd0, d}, {8'd0, last_cap[7:0]});

    drive_pin(0, 0);
    bus_read(8'h13, d);
    drive_pin(1, 1);
    pop_check("R1 capture value");
    chk("R6 clear needs flag-set status", {15'd0, cap_flag}, 16'd1);

    drive_pin(0, 0);
    bus_read(8'h13, d);
    drive_pin(1, 1);
    pop_check("R6 capture between status and lo");
    chk("R6 capture in between keeps flag", {15'd0, cap_flag}, 16'd1);
    clear_flag();
    chk("R6 clear after", {15'd0, cap_flag}, 16'd0);

    drive_pin(0, 0);
    drive_pin(1, 1);
    pop_check("R1 capture value");
    drive_pin(0, 0);
    bus_read(8'h13, d);
    @(negedge clk); cap_pin = 1;
    @(negedge clk);
    @(negedge clk); rd_en = 1; addr = 8'h15;
    #1 snap = cnt; d = rdata;
    @(negedge clk); rd_en = 0;
    chk("R6 same-cycle lo old byte", {8'd0, d}, {8'd0, last_cap[7:0]});
    chk("R6 same-cycle capture keeps flag", {15'd0, cap_flag}, 16'd1);
    exp_q.push_back(snap);
    pop_check("R6 same-cycle capture value");

    bus_write(8'h14, 8'hA5);
    bus_write(8'h15, 8'h5A);
    bus_write(8'h13, 8'h00);
    chk("R7 write leaves flag", {15'd0, cap_flag}, 16'd1);
    pop_check("R7 write leaves capture");

    drive_pin(0, 0);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1 chk("R8 reset clears flag", {15'd0, cap_flag}, 16'd0);
    pop_check("R8 capture kept through reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule